// File: doc/BRIEF.md
# Fused Multiply-Add Invalid-Result Resolver

This block sits next to a single-precision fused multiply-add core that can either add the product to the addend (`a*b + c`) or subtract the product from it (`c - a*b`). It receives the three operands, the operation select, and the raw result and invalid-operation flag from the core. From these it produces the final 32-bit result.

When the core reports no invalid operation, the core's value is passed on unchanged. When the core does report one, the block checks what caused it and replaces the result with a quiet NaN code that names the cause. The causes are checked in a fixed priority order: a NaN operand, then infinity times zero, then infinity minus infinity. If the flag is set but none of these causes matches, the core's value is kept. Before the checks, every denormal operand is treated as a zero of the same sign.

The block registers its result one cycle after a valid input. It also brings out the invalid flag it captured.

Top module: `fmares_top`

## Requirements
- R1: While `core_invalid` is 0, the captured result equals `core_result`, even if the operands hold NaNs or infinities.
- R2: If `core_invalid` is 1 and any of the three operands is a NaN, the result is 0x7FC00000. A NaN is an operand with exponent field [30:23] = 0xFF and a nonzero mantissa [22:0]. Quiet and signalling NaNs are treated the same.
- R3: If `core_invalid` is 1, no operand is a NaN, and one multiplicand is an infinity while the other is a zero (in either order, of either sign), the result is 0x7FC00002.
- R4: If `core_invalid` is 1 with `op_sub` = 0, none of the cases above matches, `a` or `b` has exponent 0xFF, `c` has exponent 0xFF, and sign(a) XOR sign(b) XOR sign(c) = 1, the result is 0x7FC00001. The sign is bit 31.
- R5: With `op_sub` = 1, the sign of `c` is inverted before the R4 sign test.
- R6: If `core_invalid` is 1 and none of the R2 to R4 cases matches, the result is `core_result`.
- R7: An operand with exponent 0 and a nonzero mantissa counts as a zero in every test above.
- R8: The NaN case takes priority over the infinity-times-zero case, and the infinity-times-zero case takes priority over the infinity-difference case.
- R9: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `out_invalid` then equals the captured `core_invalid`.
- R10: While `rst` is high, the next clock edge drives `out_valid`, `out_result` and `out_invalid` to 0.
- R11: In a cycle with `in_valid` low, `out_result` and `out_invalid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and core outputs are valid this cycle |
| op_sub | input | 1 | 0: a*b+c, 1: c-a*b |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| opnd_c | input | 32 | Addend |
| core_result | input | 32 | Raw result from the arithmetic core |
| core_invalid | input | 1 | Invalid-operation flag from the core |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Final result |
| out_invalid | output | 1 | Captured invalid status |

## Verification
Two of the cause detectors can match on the same operation. The bench provokes this by sending an infinity times zero together with a NaN addend. It then checks that the NaN code wins.

The bench also combines a denormal multiplicand with an infinite one. This makes the flush and the infinity-times-zero detection act together, and the expected result is the 0x7FC00002 code. Both sign polarities of the infinity-difference test are run under each operation select. This shows that inverting the addend sign flips which cases are replaced and which are kept.

// File: rtl/fmares_pkg.sv
package fmares_pkg;

    localparam int EXP_W = 8;
    localparam int MAN_W = 23;
    localparam int FP_W  = 1 + EXP_W + MAN_W;

    localparam logic [FP_W-1:0] CODE_NAN_IN   = 32'h7FC0_0000;
    localparam logic [FP_W-1:0] CODE_INF_DIFF = 32'h7FC0_0001;
    localparam logic [FP_W-1:0] CODE_INF_ZERO = 32'h7FC0_0002;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef struct packed {
        logic sign;
        logic exp_max;
        logic is_nan;
        logic is_inf;
        logic is_zero;
    } cls_t;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_NAN,
        CAUSE_INF_ZERO,
        CAUSE_INF_DIFF
    } cause_e;

    function automatic fp_t flush_denorm(fp_t x);
        fp_t y;
        y = x;
        if (x.exp == '0) y.man = '0;
        return y;
    endfunction

    function automatic logic [FP_W-1:0] cause_code(cause_e c, logic [FP_W-1:0] raw);
        logic [FP_W-1:0] r;
        case (c)
            CAUSE_NAN:      r = CODE_NAN_IN;
            CAUSE_INF_ZERO: r = CODE_INF_ZERO;
            CAUSE_INF_DIFF: r = CODE_INF_DIFF;
            default:        r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fmares_classify.sv
module fmares_classify
    import fmares_pkg::*;
(
    input  fp_t  opnd,
    output cls_t cls
);
    fp_t flushed;

    always_comb begin
        flushed     = flush_denorm(opnd);
        cls.sign    = flushed.sign;
        cls.exp_max = &flushed.exp;
        cls.is_nan  = cls.exp_max & (|flushed.man);
        cls.is_inf  = cls.exp_max & ~(|flushed.man);
        cls.is_zero = (flushed.exp == '0);
    end
endmodule

// File: rtl/fmares_priority.sv
module fmares_priority
    import fmares_pkg::*;
(
    input  cls_t   cls_a,
    input  cls_t   cls_b,
    input  cls_t   cls_c,
    input  logic   op_sub,
    output cause_e cause
);
    logic any_nan;
    logic mul_bad;
    logic eff_c_sign;
    logic diff_bad;

    always_comb begin
        any_nan    = cls_a.is_nan | cls_b.is_nan | cls_c.is_nan;
        mul_bad    = (cls_a.is_inf & cls_b.is_zero) | (cls_a.is_zero & cls_b.is_inf);
        eff_c_sign = cls_c.sign ^ op_sub;
        diff_bad   = (cls_a.exp_max | cls_b.exp_max) & cls_c.exp_max
                   & (cls_a.sign ^ cls_b.sign ^ eff_c_sign);
        if (any_nan)       cause = CAUSE_NAN;
        else if (mul_bad)  cause = CAUSE_INF_ZERO;
        else if (diff_bad) cause = CAUSE_INF_DIFF;
        else               cause = CAUSE_NONE;
    end
endmodule

// File: rtl/fmares_top.sv
module fmares_top
    import fmares_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            op_sub,
    input  logic [FP_W-1:0] opnd_a,
    input  logic [FP_W-1:0] opnd_b,
    input  logic [FP_W-1:0] opnd_c,
    input  logic [FP_W-1:0] core_result,
    input  logic            core_invalid,
    output logic            out_valid,
    output logic [FP_W-1:0] out_result,
    output logic            out_invalid
);
    localparam int N_OPND = 3;

    fp_t    opnds [N_OPND];
    cls_t   cls   [N_OPND];
    cause_e cause;
    logic [FP_W-1:0] final_res;

    assign opnds[0] = opnd_a;
    assign opnds[1] = opnd_b;
    assign opnds[2] = opnd_c;

    for (genvar i = 0; i < N_OPND; i++) begin : g_cls
        fmares_classify u_cls (
            .opnd (opnds[i]),
            .cls  (cls[i])
        );
    end

    fmares_priority u_prio (
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .cls_c  (cls[2]),
        .op_sub (op_sub),
        .cause  (cause)
    );

    always_comb begin
        final_res = core_invalid ? cause_code(cause, core_result) : core_result;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= final_res;
                out_invalid <= core_invalid;
            end
        end
    end

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid) || $past(rst));

    // R10
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && !out_invalid));

    // R1
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !core_invalid) |=> out_result == $past(core_result));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_invalid)));

    // R2
    nan_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && core_invalid && (cls[0].is_nan || cls[1].is_nan || cls[2].is_nan))
        |=> out_result == CODE_NAN_IN);

    // R3
    inf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && core_invalid && !cls[0].is_nan && !cls[1].is_nan && !cls[2].is_nan
         && ((cls[0].is_inf && cls[1].is_zero) || (cls[0].is_zero && cls[1].is_inf)))
        |=> out_result == CODE_INF_ZERO);

endmodule

// File: tb/tb_fmares_top.sv
module tb_fmares_top;

    typedef struct packed {
        logic        sub;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] core;
        logic        inv;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
    localparam logic [31:0] QN = 32'h7FC0_0005, SN = 32'h7F80_0001;
    localparam logic [31:0] ONE = 32'h3F80_0000, NONE = 32'hBF80_0000, TWO = 32'h4000_0000;
    localparam logic [31:0] DEN = 32'h0000_0123, NDEN = 32'h8000_0010;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, ONE,  TWO,  ONE,  32'h4040_0000, 1'b0, 32'h4040_0000, "R1 "},
        '{1'b0, SN,   ONE,  PZ,   32'h7FC1_2345, 1'b0, 32'h7FC1_2345, "R1 "},
        '{1'b0, QN,   ONE,  ONE,  32'hDEAD_BEEF, 1'b1, 32'h7FC0_0000, "R2 "},
        '{1'b1, ONE,  ONE,  SN,   32'hDEAD_BEEF, 1'b1, 32'h7FC0_0000, "R2 "},
        '{1'b0, PINF, PZ,   QN,   32'hDEAD_BEEF, 1'b1, 32'h7FC0_0000, "R8 "},
        '{1'b0, PINF, PZ,   ONE,  32'hDEAD_BEEF, 1'b1, 32'h7FC0_0002, "R3 "},
        '{1'b1, NZ,   NINF, ONE,  32'hDEAD_BEEF, 1'b1, 32'h7FC0_0002, "R3 "},
        '{1'b0, PINF, ONE,  NINF, 32'hDEAD_BEEF, 1'b1, 32'h7FC0_0001, "R4 "},
        '{1'b0, PINF, ONE,  PINF, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, "R6 "},
        '{1'b1, PINF, ONE,  PINF, 32'hDEAD_BEEF, 1'b1, 32'h7FC0_0001, "R5 "},
        '{1'b1, PINF, ONE,  NINF, 32'h1234_5678, 1'b1, 32'h1234_5678, "R5 "},
        '{1'b1, TWO,  NINF, NINF, 32'h1234_5678, 1'b1, 32'h7FC0_0001, "R5 "},
        '{1'b0, PINF, DEN,  ONE,  32'hDEAD_BEEF, 1'b1, 32'h7FC0_0002, "R7 "},
        '{1'b0, NDEN, NINF, ONE,  32'hDEAD_BEEF, 1'b1, 32'h7FC0_0002, "R7 "},
        '{1'b0, DEN,  TWO,  ONE,  32'hABCD_0000, 1'b1, 32'hABCD_0000, "R6 "},
        '{1'b0, NONE, PINF, PINF, 32'hDEAD_BEEF, 1'b1, 32'h7FC0_0001, "R4 "}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, core_result = '0;
    logic        core_invalid = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fmares_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .core_result(core_result), .core_invalid(core_invalid),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #100000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {31'd0, out_valid}, 32'd0);
        check("R10", out_result, 32'd0);
        check("R10", {31'd0, out_invalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_valid     = 1'b1;
            op_sub       = VECS[i].sub;
            opnd_a       = VECS[i].a;
            opnd_b       = VECS[i].b;
            opnd_c       = VECS[i].c;
            core_result  = VECS[i].core;
            core_invalid = VECS[i].inv;
            @(negedge clk);
            check($sformatf("%s", VECS[i].tag), out_result, VECS[i].exp);
            // R9: valid and invalid status one cycle later
            check("R9", {31'd0, out_valid}, 32'd1);
            check("R9", {31'd0, out_invalid}, {31'd0, VECS[i].inv});
        end

        // R11: idle cycle with provoking inputs leaves outputs held
        in_valid     = 1'b0;
        opnd_a       = QN;
        core_result  = 32'h5555_5555;
        core_invalid = 1'b0;
        @(negedge clk);
        check("R11", out_result, VECS[NV-1].exp);
        check("R11", {31'd0, out_invalid}, 32'd1);
        check("R9", {31'd0, out_valid}, 32'd0);

        // R10: reset during a valid input
        in_valid = 1'b1;
        rst      = 1'b1;
        @(negedge clk);
        check("R10", {31'd0, out_valid}, 32'd0);
        check("R10", out_result, 32'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule